// File: doc/BRIEF.md
# Two-Range Serial ADC Current Sampler

This block reads an 8-bit serial analog-to-digital converter at a fixed rate and produces signed current samples with an effective 10-bit span. At every sample interval it lowers a chip-select and sends eight serial clock pulses. It shifts in the offset-binary code, one bit per rising clock edge, most significant bit first. The code is turned into two's complement. The result is then scaled to a common unit of 1/8 ampere, so the consumer sees one number line whatever the gain.

The converter starts a new conversion on the last clock pulse of each burst. The code read in any burst therefore belongs to the conversion that the previous burst started, and it must be scaled with the gain that was selected at that moment. A range output drives the external analog gain switch. Normal gain gives 1/8 A per count. Low gain gives one quarter of that gain, so each count is 1/2 A and the result is multiplied by four. The block enters low gain as soon as a sample magnitude passes 14 A. It returns to normal gain only after a run of quiet samples, each below 12 A. The length of that run is set by a programmable hold count.

Top module: `range_adc_sampler`

## Requirements
- R1: Each burst holds `adc_cs_n` low and gives exactly ADC_W (8) rising edges on `adc_sclk`. The serial clock idles low while `adc_cs_n` is high. Bursts start every INTERVAL_CYC clock cycles.
- R2: Data bits are captured from `adc_sdo` on each rising serial-clock edge, most significant bit first.
- R3: The first burst after reset produces no `sample_vld`. Every later burst produces a single-cycle `sample_vld` pulse. Its value comes from the conversion started at the previous burst's last clock pulse.
- R4: In normal gain the output equals the code minus 128, for example code 0x80 gives 0 and code 0x00 gives -128. The output lies within -128 to 127.
- R5: In low gain the output equals (code minus 128) times 4. Its two least significant bits are therefore zero.
- R6: The gain used to scale a sample is the value `range_lo` had when that sample's conversion started, not its value when the sample is read.
- R7: `range_lo` (1 = low gain) goes high in the cycle after a valid sample whose magnitude exceeds 112 counts (14 A). A magnitude of exactly 112 does not cause a switch.
- R8: While `range_lo` is high, it falls in the cycle after the `hold_cfg`-th consecutive valid sample with a magnitude below 96 counts (12 A). A hold value of 0 acts as 1. A sample with a magnitude from 96 to 112 restarts the count.
- R9: Under reset `adc_cs_n` is 1, and `adc_sclk`, `sample_vld`, `range_lo` and `sample` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_cfg | input | HOLD_W (8) | Number of quiet samples needed before returning to normal gain |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| sample | output | OUT_W (10) | Signed current sample in units of 1/8 A |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |
| range_lo | output | 1 | Gain switch command, 1 selects low gain |

## Verification
The assertions assume three things. First, `adc_sdo` holds steady around each rising serial-clock edge. Second, `hold_cfg` does not change near a `sample_vld` pulse. Third, a full burst of 16·HALF_CYC cycles fits inside INTERVAL_CYC. The bench converter model changes `adc_sdo` only when chip-select falls or the serial clock falls, at least HALF_CYC cycles before the next capture. It changes `hold_cfg` only at the end of a burst, far from any strobe. Its parameters give a 32-cycle burst in a 64-cycle interval.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic {
    RNG_NORMAL = 1'b0,
    RNG_LOW    = 1'b1
  } rng_e;
endpackage

// File: rtl/adcs_seq.sv
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int ADC_W        = 8,
  parameter int HALF_CYC     = 25,
  parameter int INTERVAL_CYC = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdo,
  input  logic             range_lo,
  output logic             cs_n,
  output logic             sclk,
  output logic [ADC_W-1:0] code,
  output logic             done,
  output logic             rdy,
  output logic             rng_use
);
  localparam int IW = $clog2(INTERVAL_CYC);
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(ADC_W + 1);

  logic [IW-1:0] icnt;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bits;
  logic          busy, primed, tick;
  rng_e          conv_rng;

  assign tick = (icnt == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) icnt <= '0;
    else if (tick) icnt <= '0;
    else icnt <= icnt + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      hcnt     <= '0;
      bits     <= '0;
      code     <= '0;
      done     <= 1'b0;
      rdy      <= 1'b0;
      primed   <= 1'b0;
      rng_use  <= 1'b0;
      conv_rng <= RNG_NORMAL;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (tick) begin
          busy <= 1'b1;
          cs_n <= 1'b0;
          hcnt <= '0;
          bits <= '0;
        end
      end else if (hcnt == HW'(HALF_CYC - 1)) begin
        hcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          code <= {code[ADC_W-2:0], sdo};
          bits <= bits + BW'(1);
          if (bits == BW'(ADC_W - 1)) begin
            done     <= 1'b1;
            rdy      <= primed;
            primed   <= 1'b1;
            rng_use  <= conv_rng;
            conv_rng <= rng_e'(range_lo);
          end
        end else begin
          sclk <= 1'b0;
          if (bits == BW'(ADC_W)) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  AST_SCLK_IN_CS: assert property (@(posedge clk) disable iff (rst) sclk |-> !cs_n); // R1
  AST_FULL_BURST: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> bits == BW'(ADC_W)); // R1
endmodule

// File: rtl/adcs_scale.sv
module adcs_scale
  import adcs_pkg::*;
#(
  parameter int ADC_W = 8,
  parameter int OUT_W = ADC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADC_W-1:0]        code,
  input  logic                    done,
  input  logic                    rdy,
  input  logic                    rng_use,
  output logic signed [OUT_W-1:0] sample,
  output logic                    vld
);
  localparam int SPAN = 1 << (ADC_W - 1);

  logic signed [ADC_W-1:0] tc;
  logic signed [OUT_W-1:0] scaled;

  assign tc = {~code[ADC_W-1], code[ADC_W-2:0]};
  assign scaled = (rng_e'(rng_use) == RNG_LOW) ? {tc, 2'b00}
                                               : {{(OUT_W-ADC_W){tc[ADC_W-1]}}, tc};

  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= done && rdy;
      if (done && rdy) sample <= scaled;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst) vld |=> !vld); // R3
  AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst) (vld && rng_use) |-> sample[1:0] == 2'b00); // R5
  AST_NORM_SPAN: assert property (@(posedge clk) disable iff (rst)
    (vld && !rng_use) |-> (sample >= OUT_W'(-SPAN) && sample <= OUT_W'(SPAN - 1))); // R4
endmodule

// File: rtl/adcs_range.sv
module adcs_range #(
  parameter int OUT_W   = 10,
  parameter int HOLD_W  = 8,
  parameter int TRIP_HI = 112,
  parameter int TRIP_LO = 96
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [HOLD_W-1:0]       hold,
  input  logic signed [OUT_W-1:0] sample,
  input  logic                    vld,
  output logic                    range_lo
);
  logic [OUT_W-1:0]  mag;
  logic [HOLD_W-1:0] qcnt;
  logic [HOLD_W:0]   qnext;

  assign mag   = sample[OUT_W-1] ? OUT_W'(-sample) : OUT_W'(sample);
  assign qnext = {1'b0, qcnt} + (HOLD_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      range_lo <= 1'b0;
      qcnt     <= '0;
    end else if (vld) begin
      if (mag > OUT_W'(TRIP_HI)) begin
        range_lo <= 1'b1;
        qcnt     <= '0;
      end else if (range_lo) begin
        if (mag < OUT_W'(TRIP_LO)) begin
          if (qnext >= {1'b0, hold}) begin
            range_lo <= 1'b0;
            qcnt     <= '0;
          end else begin
            qcnt <= qnext[HOLD_W-1:0];
          end
        end else begin
          qcnt <= '0;
        end
      end
    end
  end

  AST_TRIP_UP: assert property (@(posedge clk) disable iff (rst)
    $rose(range_lo) |-> ($past(vld) && $past(mag) > OUT_W'(TRIP_HI))); // R7
  AST_TRIP_DOWN: assert property (@(posedge clk) disable iff (rst)
    $fell(range_lo) |-> ($past(vld) && $past(mag) < OUT_W'(TRIP_LO))); // R8
endmodule

// File: rtl/range_adc_sampler.sv
module range_adc_sampler #(
  parameter int ADC_W        = 8,
  parameter int HALF_CYC     = 25,
  parameter int INTERVAL_CYC = 25000,
  parameter int HOLD_W       = 8,
  parameter int TRIP_HI      = 112,
  parameter int TRIP_LO      = 96,
  parameter int OUT_W        = ADC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [HOLD_W-1:0]       hold_cfg,
  input  logic                    adc_sdo,
  output logic                    adc_cs_n,
  output logic                    adc_sclk,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_vld,
  output logic                    range_lo
);
  logic [ADC_W-1:0] code;
  logic             done, rdy, rng_use;

  adcs_seq #(
    .ADC_W(ADC_W), .HALF_CYC(HALF_CYC), .INTERVAL_CYC(INTERVAL_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .sdo(adc_sdo), .range_lo(range_lo),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .code(code),
    .done(done), .rdy(rdy), .rng_use(rng_use)
  );

  adcs_scale #(
    .ADC_W(ADC_W), .OUT_W(OUT_W)
  ) u_scale (
    .clk(clk), .rst(rst), .code(code), .done(done), .rdy(rdy),
    .rng_use(rng_use), .sample(sample), .vld(sample_vld)
  );

  adcs_range #(
    .OUT_W(OUT_W), .HOLD_W(HOLD_W), .TRIP_HI(TRIP_HI), .TRIP_LO(TRIP_LO)
  ) u_range (
    .clk(clk), .rst(rst), .hold(hold_cfg), .sample(sample),
    .vld(sample_vld), .range_lo(range_lo)
  );
endmodule

// File: tb/range_adc_sampler_tb.sv
module range_adc_sampler_tb;
  localparam int HALF = 2;
  localparam int IVL  = 64;
  localparam int NCONV = 34;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        hold_cfg = 8'd3;
  logic              adc_sdo = 1'b0;
  logic              adc_cs_n, adc_sclk, sample_vld, range_lo;
  logic signed [9:0] sample;

  range_adc_sampler #(.HALF_CYC(HALF), .INTERVAL_CYC(IVL)) u_dut (
    .clk(clk), .rst(rst), .hold_cfg(hold_cfg), .adc_sdo(adc_sdo),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .sample(sample),
    .sample_vld(sample_vld), .range_lo(range_lo)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int expq[$];
  int cur[32] = '{0, 5, -7, 127, -128, 112, -112, 113, 120, 200, -300, 508, 600, 100, 92, 88,
                  100, 92, 88, 84, 40, 20, -20, 0, -113, 0, 0, 3, -3, 0, 0, 0};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_expected(input int cur_q, input bit r, output logic [7:0] code);
    int c;
    c = r ? (cur_q >>> 2) : cur_q;
    if (c > 127) c = 127;
    if (c < -128) c = -128;
    code = 8'(c + 128);
    expq.push_back(r ? c * 4 : c);
  endtask

  // converter model and driver
  int k = 0, rises = 0, bursts = 0, last_fall = -1;
  logic [7:0] conv = 8'h5A, outr = 8'h00;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !adc_cs_n) begin
        if (last_fall >= 0) chk(cyc - last_fall == IVL, "R1 interval", cyc - last_fall, IVL);
        last_fall = cyc;
        outr = conv; adc_sdo = outr[7]; rises = 0;
      end
      if (!prev_sclk && adc_sclk) begin
        rises++;
        if (rises == 8) begin
          push_expected((k < 32) ? cur[k] : 0, range_lo, conv);
          k++;
          if (k == 24) hold_cfg = 8'd0;
        end
      end
      if (prev_sclk && !adc_sclk) begin
        outr = outr << 1; adc_sdo = outr[7];
      end
      if (!prev_cs && adc_cs_n) begin
        chk(rises == 8, "R1 edges", rises, 8);
        bursts++;
      end
      prev_cs = adc_cs_n; prev_sclk = adc_sclk;
    end
  end

  // monitor / scoreboard
  bit mr = 1'b0, pend = 1'b0;
  int qc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        chk(range_lo == mr, mr ? "R7 range_lo" : "R8 range_lo", int'(range_lo), int'(mr));
        pend = 1'b0;
      end
      if (sample_vld) begin
        int e, a, m;
        chk(bursts >= 1, "R3 no strobe from first burst", bursts, 1);
        a = int'(sample);
        if (expq.size() == 0) begin
          chk(1'b0, "R3 unexpected strobe", a, 0);
        end else begin
          e = expq.pop_front();
          chk(a == e, "R2/R4/R5/R6 sample", a, e);
          m = (e < 0) ? -e : e;
          if (m > 112) begin mr = 1'b1; qc = 0; end
          else if (mr) begin
            if (m < 96) begin
              if (qc + 1 >= int'(hold_cfg)) begin mr = 1'b0; qc = 0; end
              else qc++;
            end else qc = 0;
          end
          pend = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R9 cs_n", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R9 sclk", int'(adc_sclk), 0);
    chk(sample_vld == 1'b0, "R9 vld", int'(sample_vld), 0);
    chk(range_lo == 1'b0, "R9 range", int'(range_lo), 0);
    chk(sample == '0, "R9 sample", int'(sample), 0);
    @(negedge clk) rst = 1'b0;
    fork
      begin
        wait (k >= NCONV);
        repeat (10) @(negedge clk);
      end
      begin
        repeat (100000) @(negedge clk);
        chk(1'b0, "watchdog", k, NCONV);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule